// File: doc/BRIEF.md
# Calendar Time Counter with Update Cycle

This block holds a calendar time (seconds, minutes, hours, day of week, day of month, month, two-digit year) in a small byte-wide register file. A host reaches it through a flat address/data port: single-cycle writes, combinational reads. A one-cycle pulse on the one-hertz tick input starts an update sequence. First comes a lead window, then an update window. When the update window closes, the time advances by one second, with the carry rippling through every calendar field.

For the whole sequence a busy flag is visible in the status register, so software knows the time is about to change. Time registers keep their old values until the sequence ends. A control register picks BCD or binary coding and 24-hour or 12-hour hours (12-hour hours carry a PM flag in bit 7). It also holds a halt bit: while the halt bit is set, no update starts, and setting it during a sequence cancels that sequence. The host can then load a new time safely. Both window lengths are parameters in reference-clock cycles.

Top module: `caltime_core`

## Requirements
- R1: After reset: seconds, minutes, hours and year read 0x00; day of week, day of month and month read 0x01; control (address 11) reads 0x02; status (address 10) reads 0x00.
- R2: Address map: seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8, year 9 (all read/write, 8 bits). Address 10 is status, with bit 7 = busy and the other bits 0; it ignores writes. Address 11 is control, with bit 7 = halt, bit 2 = binary coding, bit 1 = 24-hour mode; its other bits read 0. Address 13 always reads 0x80 (time valid). Addresses 1, 3, 5, 12, 14 and 15 read 0x00 and ignore writes.
- R3: A tick sampled high while idle and not halted raises busy at the next clock edge. Busy then stays high for exactly LEAD_CYC + UPD_CYC cycles.
- R4: While busy, the time registers read their pre-update values. At the edge where busy falls, the time has advanced by exactly one second.
- R5: A tick that arrives while busy is ignored and starts no second update.
- R6: While halt is set, a tick starts no update. Setting halt during an update clears busy and cancels that advance.
- R7: With bit 2 of control clear, all time fields are BCD and carry per decimal digit (for example 0x09 to 0x10, and 0x59 to 0x00 with carry).
- R8: With bit 2 of control set, all fields are plain binary and use the same rollover limits.
- R9: In 24-hour mode, hours count 0 to 23, and 23 rolls to 0 with a carry into the date.
- R10: In 12-hour mode, hours run 12, 1, ..., 11 with bit 7 = PM. 11 AM goes to 12 PM (bit 7 set). 11 PM goes to 12 AM (bit 7 clear) and advances the date. 12 goes to 1 with the same PM bit.
- R11: Day of week counts 1 to 7 and advances with each day; 7 wraps to 1.
- R12: Day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11; 29 for month 2 when the year is divisible by 4, else 28; 31 otherwise. Month 12 wraps to 1 and increments the year, which wraps from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
The hardest case is the full cascade: one second ripples through minute, hour, day, month and year together, and that can only happen from a loaded end-of-year time. The bench reaches it by halting the counter, writing 23:59:59 on 31 December of year 99 (or 11 PM in 12-hour form), releasing halt and sending a single tick. It then reads every field once busy has fallen. Leap-year February and the 30-day months are reached the same way in both codings. The cancelled update is reached by writing halt a few cycles into a running sequence.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_DOW  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DOM  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd8;
  localparam logic [ADDR_W-1:0] A_YR   = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd10;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'd11;
  localparam logic [ADDR_W-1:0] A_VLD  = 4'd13;

  // control bit positions
  localparam int CB_HALT = 7;
  localparam int CB_BIN  = 2;
  localparam int CB_H24  = 1;
  localparam logic [DATA_W-1:0] CTL_MASK  = 8'h86;
  localparam logic [DATA_W-1:0] CTL_RESET = 8'h02;
  localparam logic [DATA_W-1:0] VLD_WORD  = 8'h80;

  // rollover limits
  localparam logic [6:0] SEC_LAST  = 7'd59;
  localparam logic [6:0] HR_LAST   = 7'd23;
  localparam logic [6:0] HR_HALF   = 7'd12;
  localparam logic [6:0] DOW_LAST  = 7'd7;
  localparam logic [6:0] MON_LAST  = 7'd12;
  localparam logic [6:0] YR_LAST   = 7'd99;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] yr;
  } cal_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_RUN} seq_st_t;

  // host-format byte to binary value
  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    logic [6:0] tens;
    tens = 7'(v[7:4]) * 7'd10;
    return bin ? v[6:0] : tens + 7'(v[3:0]);
  endfunction

  // binary value to host-format byte
  function automatic logic [7:0] from_bin(input logic [6:0] b, input logic bin);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = 4'(b / 7'd10);
    lo = 4'(b % 7'd10);
    return bin ? {1'b0, b} : {hi, lo};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    logic leap;
    leap = (yr[1:0] == 2'b00);
    case (mon)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/caltime_seq.sv
module caltime_seq
  import caltime_pkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int UPD_CYC  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic halt,
  output logic busy,
  output logic commit
);

  localparam int MAXC = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LOAD = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] UPD_LOAD  = CW'(UPD_CYC - 1);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    commit = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (tick && !halt) begin
          st_d  = SQ_LEAD;
          cnt_d = LEAD_LOAD;
        end
      end
      SQ_LEAD: begin
        if (halt) begin
          st_d = SQ_IDLE;
        end else if (cnt_q == '0) begin
          st_d  = SQ_RUN;
          cnt_d = UPD_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_RUN: begin
        if (halt) begin
          st_d = SQ_IDLE;
        end else if (cnt_q == '0) begin
          st_d   = SQ_IDLE;
          commit = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != SQ_IDLE);

endmodule

// File: rtl/caltime_step.sv
module caltime_step
  import caltime_pkg::*;
(
  input  cal_t cur,
  input  logic bin,
  input  logic h24,
  output cal_t nxt
);

  logic [6:0] s_b, m_b, h12_b, h_b, dw_b, dm_b, mo_b, y_b;
  logic [6:0] s_n, m_n, h_n, dw_n, dm_n, mo_n, y_n;
  logic [6:0] h_mod, h_12n, dim;
  logic [7:0] h_enc;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s_b   = to_bin(cur.sec, bin);
    m_b   = to_bin(cur.min, bin);
    h12_b = to_bin({1'b0, cur.hr[6:0]}, bin);
    h_b   = h24 ? to_bin(cur.hr, bin)
                : ((h12_b == HR_HALF) ? 7'd0 : h12_b) + (cur.hr[7] ? HR_HALF : 7'd0);
    dw_b  = to_bin(cur.dow, bin);
    dm_b  = to_bin(cur.dom, bin);
    mo_b  = to_bin(cur.mon, bin);
    y_b   = to_bin(cur.yr, bin);
    dim   = month_len(mo_b, y_b);

    // carry chain, seconds first
    c_min = (s_b >= SEC_LAST);
    s_n   = c_min ? 7'd0 : s_b + 7'd1;
    c_hr  = c_min && (m_b >= SEC_LAST);
    m_n   = (m_b >= SEC_LAST) ? 7'd0 : m_b + 7'd1;
    c_day = c_hr && (h_b >= HR_LAST);
    h_n   = (h_b >= HR_LAST) ? 7'd0 : h_b + 7'd1;
    dw_n  = (dw_b >= DOW_LAST) ? 7'd1 : dw_b + 7'd1;
    c_mon = c_day && (dm_b >= dim);
    dm_n  = (dm_b >= dim) ? 7'd1 : dm_b + 7'd1;
    c_yr  = c_mon && (mo_b >= MON_LAST);
    mo_n  = (mo_b >= MON_LAST) ? 7'd1 : mo_b + 7'd1;
    y_n   = (y_b >= YR_LAST) ? 7'd0 : y_b + 7'd1;

    // hour re-encoding for the selected hour mode
    h_mod = h_n % HR_HALF;
    h_12n = (h_mod == 7'd0) ? HR_HALF : h_mod;
    h_enc = from_bin(h_12n, bin);

    nxt.sec = from_bin(s_n, bin);
    nxt.min = c_min ? from_bin(m_n, bin) : cur.min;
    nxt.hr  = !c_hr ? cur.hr
            : h24   ? from_bin(h_n, bin)
                    : {(h_n >= HR_HALF), h_enc[6:0]};
    nxt.dow = c_day ? from_bin(dw_n, bin) : cur.dow;
    nxt.dom = c_day ? from_bin(dm_n, bin) : cur.dom;
    nxt.mon = c_mon ? from_bin(mo_n, bin) : cur.mon;
    nxt.yr  = c_yr  ? from_bin(y_n, bin)  : cur.yr;
  end

endmodule

// File: rtl/caltime_regs.sv
module caltime_regs
  import caltime_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  input  cal_t              nxt,
  output cal_t              time_q,
  output logic [DATA_W-1:0] ctl_q
);

  cal_t              time_d;
  logic [DATA_W-1:0] ctl_d;
  logic              time_en, ctl_en;

  always_comb begin
    time_d = commit ? nxt : time_q;
    ctl_d  = ctl_q;
    if (wr_en) begin
      case (addr)
        A_SEC: time_d.sec = wdata;
        A_MIN: time_d.min = wdata;
        A_HR:  time_d.hr  = wdata;
        A_DOW: time_d.dow = wdata;
        A_DOM: time_d.dom = wdata;
        A_MON: time_d.mon = wdata;
        A_YR:  time_d.yr  = wdata;
        A_CTL: ctl_d      = wdata & CTL_MASK;
        default: ;
      endcase
    end
    time_en = commit || wr_en;
    ctl_en  = wr_en && (addr == A_CTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                  dom: 8'h01, mon: 8'h01, yr: 8'h00};
      ctl_q  <= CTL_RESET;
    end else begin
      if (time_en) time_q <= time_d;
      if (ctl_en)  ctl_q  <= ctl_d;
    end
  end

endmodule

// File: rtl/caltime_core.sv
module caltime_core
  import caltime_pkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int UPD_CYC  = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       busy, commit, halt_q;
  logic [7:0] sec_cur;
  cal_t       time_q, nxt;
  logic [7:0] ctl_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign halt_q  = ctl_q[CB_HALT];
  assign sec_cur = time_q.sec;

  caltime_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick_1hz), .halt(halt_q),
    .busy(busy), .commit(commit)
  );

  caltime_step step_i (
    .cur(time_q), .bin(ctl_q[CB_BIN]), .h24(ctl_q[CB_H24]), .nxt(nxt)
  );

  caltime_regs regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .commit(commit), .nxt(nxt), .time_q(time_q), .ctl_q(ctl_q)
  );

  always_comb begin
    case (addr)
      A_SEC:   rdata = time_q.sec;
      A_MIN:   rdata = time_q.min;
      A_HR:    rdata = time_q.hr;
      A_DOW:   rdata = time_q.dow;
      A_DOM:   rdata = time_q.dom;
      A_MON:   rdata = time_q.mon;
      A_YR:    rdata = time_q.yr;
      A_STAT:  rdata = {busy, 7'b0};
      A_CTL:   rdata = ctl_q;
      A_VLD:   rdata = VLD_WORD;
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/caltime_chk.sv
module caltime_chk #(
  parameter int LEAD_CYC = 8,
  parameter int UPD_CYC  = 65
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       busy,
  input logic       halt,
  input logic       wr_en,
  input logic [7:0] sec
);

  localparam int SPAN = LEAD_CYC + UPD_CYC;

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R3: an accepted tick raises busy on the next edge
  a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy && !halt) |=> busy);

  // R3: a completed sequence spans exactly the two windows
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(halt)) |-> (run_len == SPAN));

  // R4: the time does not move while busy unless the host writes
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en) |=> ($stable(sec) || !busy));

  // R4: a completed sequence changes the seconds
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(halt) && !$past(wr_en)) |-> (sec != $past(sec)));

  // R6: halt ends or blocks any sequence
  a_r6_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !busy);

endmodule

bind caltime_core caltime_chk #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick_1hz), .busy(busy),
  .halt(halt_q), .wr_en(wr_en), .sec(sec_cur)
);

// File: tb/caltime_core_tb_top.sv
module caltime_core_tb_top;

  localparam int CLK_P = 10;
  localparam int LEAD  = 3;
  localparam int UPD   = 5;
  localparam int SPAN  = LEAD + UPD;

  logic       clk, rst_n, tick_1hz, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;

  int total, bad;
  bit done;

  caltime_core #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(a, v);
    chk(req, $sformatf("addr %0d", a), v, exp);
  endtask

  task automatic tick_pulse();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic do_update();
    tick_pulse();
    repeat (SPAN) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] mode, input logic [7:0] hr, input logic [7:0] mi,
                      input logic [7:0] s, input logic [7:0] dw, input logic [7:0] dm,
                      input logic [7:0] mo, input logic [7:0] y);
    wr(4'd11, mode | 8'h80);
    wr(4'd0, s); wr(4'd2, mi); wr(4'd4, hr); wr(4'd6, dw);
    wr(4'd7, dm); wr(4'd8, mo); wr(4'd9, y);
    wr(4'd11, mode);
  endtask

  task automatic expect_all(input string req, input logic [7:0] hr, input logic [7:0] mi,
                            input logic [7:0] s, input logic [7:0] dw, input logic [7:0] dm,
                            input logic [7:0] mo, input logic [7:0] y);
    rd_chk(req, 4'd0, s);  rd_chk(req, 4'd2, mi); rd_chk(req, 4'd4, hr);
    rd_chk(req, 4'd6, dw); rd_chk(req, 4'd7, dm); rd_chk(req, 4'd8, mo);
    rd_chk(req, 4'd9, y);
  endtask

  // R1
  task automatic t_reset();
    expect_all("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    rd_chk("R1", 4'd11, 8'h02);
    rd_chk("R1", 4'd10, 8'h00);
  endtask

  // R2
  task automatic t_map();
    rd_chk("R2", 4'd13, 8'h80);
    wr(4'd1, 8'h55);  rd_chk("R2", 4'd1, 8'h00);
    wr(4'd5, 8'hAA);  rd_chk("R2", 4'd5, 8'h00);
    wr(4'd12, 8'hFF); rd_chk("R2", 4'd12, 8'h00);
    wr(4'd10, 8'hFF); rd_chk("R2", 4'd10, 8'h00);
    wr(4'd13, 8'h00); rd_chk("R2", 4'd13, 8'h80);
    wr(4'd11, 8'hFF); rd_chk("R2", 4'd11, 8'h86);
    wr(4'd11, 8'h02);
    wr(4'd0, 8'h33);  rd_chk("R2", 4'd0, 8'h33);
  endtask

  // R3 R4 R5
  task automatic t_timing();
    logic [7:0] v;
    load(8'h02, 8'h08, 8'h20, 8'h10, 8'h02, 8'h05, 8'h03, 8'h21);
    tick_pulse();
    peek(4'd10, v); chk("R3", "busy after tick", v, 8'h80);
    for (int i = 1; i < SPAN; i++) begin
      @(negedge clk);
      tick_1hz = (i == 2);
      peek(4'd10, v); chk("R3", $sformatf("busy cycle %0d", i), v, 8'h80);
      peek(4'd0, v);  chk("R4", $sformatf("sec held cycle %0d", i), v, 8'h10);
    end
    @(negedge clk);
    tick_1hz = 1'b0;
    peek(4'd10, v); chk("R3", "busy fell", v, 8'h00);
    peek(4'd0, v);  chk("R4", "sec advanced", v, 8'h11);
    repeat (SPAN + 2) @(negedge clk);
    peek(4'd10, v); chk("R5", "no second update busy", v, 8'h00);
    peek(4'd0, v);  chk("R5", "no second update sec", v, 8'h11);
  endtask

  // R6
  task automatic t_halt();
    logic [7:0] v;
    wr(4'd11, 8'h82);
    tick_pulse();
    peek(4'd10, v); chk("R6", "halted no busy", v, 8'h00);
    repeat (SPAN + 2) @(negedge clk);
    peek(4'd0, v);  chk("R6", "halted sec", v, 8'h11);
    wr(4'd11, 8'h02);
    tick_pulse();
    wr(4'd11, 8'h82);
    @(negedge clk);
    peek(4'd10, v); chk("R6", "cancel busy", v, 8'h00);
    wr(4'd11, 8'h02);
    repeat (SPAN + 2) @(negedge clk);
    peek(4'd0, v);  chk("R6", "cancel sec", v, 8'h11);
  endtask

  // R7 R9 R11 R12: BCD 24h full cascade
  task automatic t_bcd();
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
    do_update();
    expect_all("R7_R9_R11_R12", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    load(8'h02, 8'h00, 8'h09, 8'h59, 8'h03, 8'h14, 8'h06, 8'h42);
    do_update();
    expect_all("R7", 8'h00, 8'h10, 8'h00, 8'h03, 8'h14, 8'h06, 8'h42);
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h04, 8'h31, 8'h01, 8'h30);
    do_update();
    expect_all("R12", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h02, 8'h30);
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h06, 8'h30);
    do_update();
    expect_all("R12", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h07, 8'h30);
  endtask

  // R8 R12 binary
  task automatic t_bin();
    load(8'h06, 8'd13, 8'd59, 8'd59, 8'd2, 8'd30, 8'd4, 8'd5);
    do_update();
    expect_all("R8", 8'd14, 8'd0, 8'd0, 8'd2, 8'd30, 8'd4, 8'd5);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd2, 8'd30, 8'd4, 8'd5);
    do_update();
    expect_all("R8_R12", 8'd0, 8'd0, 8'd0, 8'd3, 8'd1, 8'd5, 8'd5);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd6, 8'd28, 8'd2, 8'd4);
    do_update();
    expect_all("R12_leap", 8'd0, 8'd0, 8'd0, 8'd7, 8'd29, 8'd2, 8'd4);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd6, 8'd28, 8'd2, 8'd5);
    do_update();
    expect_all("R12_common", 8'd0, 8'd0, 8'd0, 8'd7, 8'd1, 8'd3, 8'd5);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd7, 8'd29, 8'd2, 8'd8);
    do_update();
    expect_all("R12_R11", 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd3, 8'd8);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd7, 8'd31, 8'd12, 8'd99);
    do_update();
    expect_all("R8_R12_year", 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0);
  endtask

  // R10 12-hour in both codings
  task automatic t_12h();
    load(8'h00, 8'h11, 8'h59, 8'h59, 8'h02, 8'h15, 8'h05, 8'h20);
    do_update();
    expect_all("R10_noon", 8'h92, 8'h00, 8'h00, 8'h02, 8'h15, 8'h05, 8'h20);
    load(8'h00, 8'h91, 8'h59, 8'h59, 8'h02, 8'h15, 8'h05, 8'h20);
    do_update();
    expect_all("R10_midnight", 8'h12, 8'h00, 8'h00, 8'h03, 8'h16, 8'h05, 8'h20);
    load(8'h00, 8'h12, 8'h59, 8'h59, 8'h03, 8'h16, 8'h05, 8'h20);
    do_update();
    expect_all("R10_one", 8'h01, 8'h00, 8'h00, 8'h03, 8'h16, 8'h05, 8'h20);
    load(8'h04, 8'h8B, 8'd59, 8'd59, 8'd3, 8'd10, 8'd9, 8'd1);
    do_update();
    expect_all("R10_bin", 8'h0C, 8'd0, 8'd0, 8'd4, 8'd11, 8'd9, 8'd1);
    load(8'h04, 8'h8C, 8'd59, 8'd59, 8'd4, 8'd11, 8'd9, 8'd1);
    do_update();
    expect_all("R10_bin_pm", 8'h81, 8'd0, 8'd0, 8'd4, 8'd11, 8'd9, 8'd1);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; tick_1hz = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_timing();
    t_halt();
    t_bcd();
    t_bin();
    t_12h();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule